// File: doc/BRIEF.md
# Column Array Boot Sequencer

This block controls how a compute array made of columns comes up from power-on reset. Software drives it through a small register port. It passes the commands on to the PLL and to the columns only when the current bring-up stage allows them. A write that arrives too early is dropped and has no effect.

The required order is fixed:

1. The PLL is started.
2. The PLL reports lock.
3. The column clocks are opened together.
4. A column reset pulse is applied. It has a guaranteed minimum length.
5. The partition map is loaded. This opens isolation only on internal column edges that join two columns of the same partition.

If the PLL loses lock while the columns are clocked, the block:

- gates the clocks at once,
- drops back to waiting for lock,
- records the event in a sticky flag.

Clearing the PLL enable returns everything to the off stage.

Register map:

| Address | Access | Contents |
|---------|--------|----------|
| 0 | write and read | Control: bit 0 requests the PLL, bit 1 requests column clocks, bit 2 requests column reset. A read returns the PLL request, whether clocks are on, and the reset request. |
| 1 | write and read | Partition map: bit i is 1 when columns i and i+1 are in the same partition. |
| 2 | read only | Status: bits [2:0] hold the stage, bit 3 holds the lock-lost flag. |
| 3 | read only | Reads as zero. |

Stage codes: off=0, waiting for lock=1, locked=2, clocks on=3, columns in reset=4, running=5.

Top module: `col_boot_seq`

## Requirements
- R1: While power-on reset is high, and on the first edge after it is released, all of the following hold: PLL enable is 0, every column clock enable is 0, every column reset is 0, every edge isolation output is 1, and status reads 0.
- R2: Register writes made while power-on reset is high are ignored. The control register reads 0 afterwards.
- R3: Writing 1 to control bit 0 raises the PLL enable on the next edge, and the stage becomes 1. The stage becomes 2 on the first edge at which the lock input is sampled high.
- R4: A write of control bit 1 before lock has no effect. The clock enables stay 0 and control bit 1 reads 0.
- R5: In stage 2, writing control bit 1 as 1 raises all column clock enables on the next edge (stage 3). In stage 3 or 5, writing bit 1 as 0 lowers them (stage 2).
- R6: In stage 3 or 5, a control write with bits 0, 1 and 2 all set raises every column reset on the next edge (stage 4). In stage 2 the same write leaves the resets low.
- R7: Column reset stays high for at least RST_HOLD cycles. A release (bit 2 written 0) issued earlier is deferred to the edge RST_HOLD cycles after the assertion. A release issued later takes effect on its own edge. Either way the stage becomes 5.
- R8: If lock goes low while clocks are on, the clock enables fall in the same cycle. On the next edge the stage becomes 1, the column resets are released, the partition map is cleared, and status bit 3 is set. Bit 3 stays set until power-on reset.
- R9: The partition map is accepted only in stage 5; writes in other stages are ignored. Isolation on internal edge i (1..NUM_COLS-1) is the inverse of map bit i-1. Edges 0 and NUM_COLS are always 1.
- R10: Writing control bit 0 as 0 returns the block to stage 0 on the next edge. Clocks, resets and the PLL enable all go low.
- R11: Readback follows the register map above. Address 1 returns the partition map and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_i | input | 1 | Asynchronous power-on reset, active high |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | REG_W | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | REG_W | Read data, combinational from reg_raddr |
| pll_lock_i | input | 1 | PLL lock indication |
| pll_en_o | output | 1 | PLL enable |
| col_clk_en_o | output | NUM_COLS | Per-column clock enables |
| col_rst_o | output | NUM_COLS | Per-column resets, active high |
| edge_iso_o | output | NUM_COLS+1 | Isolation enable per column edge, edge 0 at the outer left |

## Verification
The assertions assume that the lock input is already synchronous to the sequencer clock and free of glitches. They also assume that each register write is a single-cycle strobe. The checks tie the reset outputs to the reset stage, the lock-gated clock opening to the locked stage, and the partition-map clearing to the pre-lock stages. The bench changes every input, lock included, only on the falling clock edge. It never raises lock before the PLL enable has been written.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_PLL_WAIT = 3'd1,
    ST_LOCKED   = 3'd2,
    ST_CLK_ON   = 3'd3,
    ST_COL_RST  = 3'd4,
    ST_RUN      = 3'd5
  } seq_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PART = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_PLL_BIT = 0;
  localparam int CTRL_CLK_BIT = 1;
  localparam int CTRL_RST_BIT = 2;
endpackage

// File: rtl/cbs_fsm.sv
`timescale 1ns/1ps
module cbs_fsm
  import cbs_pkg::*;
(
  input  logic       clk,
  input  logic       por_i,
  input  logic       ctrl_wr,
  input  logic       wd_pll,
  input  logic       wd_clk,
  input  logic       wd_rst,
  input  logic       pll_lock,
  input  logic       rst_release,
  output seq_state_e state_o,
  output logic       pll_en_o,
  output logic       lock_lost_o,
  output logic       clocks_on_o,
  output logic       rst_start_o,
  output logic       abort_o
);
  seq_state_e st_q, st_d;
  logic pll_en_q, pll_en_d;
  logic lock_lost_q;
  logic lock_drop;
  logic clocks_on;
  logic rst_start;

  assign pll_en_d  = ctrl_wr ? wd_pll : pll_en_q;
  assign clocks_on = st_q inside {ST_CLK_ON, ST_COL_RST, ST_RUN};
  assign lock_drop = !pll_lock &&
                     (st_q inside {ST_LOCKED, ST_CLK_ON, ST_COL_RST, ST_RUN});

  always_comb begin
    st_d      = st_q;
    rst_start = 1'b0;
    if (!pll_en_d) begin
      st_d = ST_OFF;
    end else if (lock_drop) begin
      st_d = ST_PLL_WAIT;
    end else begin
      case (st_q)
        ST_OFF:      st_d = ST_PLL_WAIT;
        ST_PLL_WAIT: if (pll_lock) st_d = ST_LOCKED;
        ST_LOCKED:   if (ctrl_wr && wd_clk) st_d = ST_CLK_ON;
        ST_CLK_ON, ST_RUN: begin
          if (ctrl_wr) begin
            if (!wd_clk) begin
              st_d = ST_LOCKED;
            end else if (wd_rst) begin
              st_d      = ST_COL_RST;
              rst_start = 1'b1;
            end
          end
        end
        ST_COL_RST:  if (rst_release) st_d = ST_RUN;
        default:     st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      st_q        <= ST_OFF;
      pll_en_q    <= 1'b0;
      lock_lost_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      pll_en_q <= pll_en_d;
      if (lock_drop && clocks_on) lock_lost_q <= 1'b1;
    end
  end

  assign state_o     = st_q;
  assign pll_en_o    = pll_en_q;
  assign lock_lost_o = lock_lost_q;
  assign clocks_on_o = clocks_on;
  assign rst_start_o = rst_start;
  assign abort_o     = !pll_en_d || lock_drop;

  // R10: the off stage and a cleared PLL enable always coincide
  p_off_tracks_pll_r10: assert property (@(posedge clk) disable iff (por_i)
    (st_q == ST_OFF) == !pll_en_q);

  // R4: clocks can only open out of the locked stage with lock present
  p_clk_after_lock_r4: assert property (@(posedge clk) disable iff (por_i)
    $rose(clocks_on) |-> ($past(st_q) == ST_LOCKED) && $past(pll_lock));

  // R8: lock-lost flag never clears outside power-on reset
  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (por_i)
    $past(lock_lost_q) |-> lock_lost_q);
endmodule

// File: rtl/cbs_rst_hold.sv
`timescale 1ns/1ps
module cbs_rst_hold #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic por_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic ctrl_wr,
  input  logic wd_rst,
  output logic active_o,
  output logic req_o,
  output logic release_o
);
  localparam int             CW     = $clog2(HOLD + 1);
  localparam logic [CW-1:0]  HOLD_C = CW'(HOLD);

  logic          active_q, req_q, req_d;
  logic [CW-1:0] cnt_q;

  assign req_d     = ctrl_wr ? wd_rst : req_q;
  assign release_o = active_q && !req_d && (cnt_q >= HOLD_C);

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      active_q <= 1'b0;
      req_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      req_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      req_q    <= 1'b1;
      cnt_q    <= CW'(1);
    end else if (active_q) begin
      if (release_o) begin
        active_q <= 1'b0;
        req_q    <= 1'b0;
        cnt_q    <= '0;
      end else begin
        req_q <= req_d;
        if (cnt_q < HOLD_C) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign active_o = active_q;
  assign req_o    = req_q;

  // R7: a normal release never comes before the minimum hold count
  p_hold_min_r7: assert property (@(posedge clk) disable iff (por_i)
    $fell(active_q) && !$past(abort_i) |-> $past(cnt_q) >= HOLD_C);
endmodule

// File: rtl/cbs_iso_map.sv
`timescale 1ns/1ps
module cbs_iso_map #(
  parameter int NCOLS = 8
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [NCOLS-2:0] map_i,
  output logic [NCOLS-2:0] map_o,
  output logic [NCOLS:0]   iso_o
);
  logic [NCOLS-2:0] map_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)        map_q <= '0;
    else if (clear_i) map_q <= '0;
    else if (load_i)  map_q <= map_i;
  end

  assign map_o = map_q;

  for (genvar e = 0; e <= NCOLS; e++) begin : g_edge
    if (e == 0 || e == NCOLS) begin : g_outer
      assign iso_o[e] = 1'b1;
    end else begin : g_inner
      assign iso_o[e] = ~map_q[e-1];
    end
  end
endmodule

// File: rtl/col_boot_seq.sv
`timescale 1ns/1ps
module col_boot_seq
  import cbs_pkg::*;
#(
  parameter  int NUM_COLS = 8,
  parameter  int RST_HOLD = 16,
  localparam int MAP_W    = NUM_COLS - 1,
  localparam int REG_W    = (MAP_W > 4) ? MAP_W : 4
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                reg_wr,
  input  logic [1:0]          reg_waddr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic [1:0]          reg_raddr,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                pll_lock_i,
  output logic                pll_en_o,
  output logic [NUM_COLS-1:0] col_clk_en_o,
  output logic [NUM_COLS-1:0] col_rst_o,
  output logic [NUM_COLS:0]   edge_iso_o
);
  seq_state_e       state;
  logic             ctrl_wr, part_wr;
  logic             pll_en, lock_lost, clocks_on, rst_start, abort;
  logic             rst_active, rst_req, rst_release;
  logic [MAP_W-1:0] part_map;

  assign ctrl_wr = reg_wr && (reg_waddr == ADDR_CTRL);
  assign part_wr = reg_wr && (reg_waddr == ADDR_PART) && (state == ST_RUN);

  cbs_fsm u_fsm (
    .clk         (clk),
    .por_i       (por_i),
    .ctrl_wr     (ctrl_wr),
    .wd_pll      (reg_wdata[CTRL_PLL_BIT]),
    .wd_clk      (reg_wdata[CTRL_CLK_BIT]),
    .wd_rst      (reg_wdata[CTRL_RST_BIT]),
    .pll_lock    (pll_lock_i),
    .rst_release (rst_release),
    .state_o     (state),
    .pll_en_o    (pll_en),
    .lock_lost_o (lock_lost),
    .clocks_on_o (clocks_on),
    .rst_start_o (rst_start),
    .abort_o     (abort)
  );

  cbs_rst_hold #(.HOLD(RST_HOLD)) u_rst_hold (
    .clk       (clk),
    .por_i     (por_i),
    .start_i   (rst_start),
    .abort_i   (abort),
    .ctrl_wr   (ctrl_wr),
    .wd_rst    (reg_wdata[CTRL_RST_BIT]),
    .active_o  (rst_active),
    .req_o     (rst_req),
    .release_o (rst_release)
  );

  cbs_iso_map #(.NCOLS(NUM_COLS)) u_iso (
    .clk     (clk),
    .por_i   (por_i),
    .load_i  (part_wr),
    .clear_i (abort),
    .map_i   (reg_wdata[MAP_W-1:0]),
    .map_o   (part_map),
    .iso_o   (edge_iso_o)
  );

  assign pll_en_o     = pll_en;
  assign col_clk_en_o = {NUM_COLS{clocks_on & pll_lock_i}};
  assign col_rst_o    = {NUM_COLS{rst_active}};

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_PLL_BIT] = pll_en;
        reg_rdata[CTRL_CLK_BIT] = clocks_on;
        reg_rdata[CTRL_RST_BIT] = rst_req;
      end
      ADDR_PART: reg_rdata[MAP_W-1:0] = part_map;
      ADDR_STAT: reg_rdata[3:0] = {lock_lost, state};
      default:   reg_rdata = '0;
    endcase
  end

  // R6: column reset held exactly while the sequencer is in its reset stage
  p_rst_in_state_r6: assert property (@(posedge clk) disable iff (por_i)
    rst_active == (state == ST_COL_RST));

  // R9: before lock every edge stays isolated
  p_iso_closed_early_r9: assert property (@(posedge clk) disable iff (por_i)
    (state inside {ST_OFF, ST_PLL_WAIT}) |-> (&edge_iso_o));
endmodule

// File: tb/col_boot_seq_tb.sv
`timescale 1ns/1ps
module col_boot_seq_tb;
  localparam int NC   = 8;
  localparam int HOLD = 16;
  localparam int RW   = 7;

  logic          clk = 1'b0;
  logic          por_i;
  logic          reg_wr;
  logic [1:0]    reg_waddr, reg_raddr;
  logic [RW-1:0] reg_wdata, reg_rdata;
  logic          pll_lock_i, pll_en_o;
  logic [NC-1:0] col_clk_en_o, col_rst_o;
  logic [NC:0]   edge_iso_o;

  always #2 clk = ~clk;

  col_boot_seq #(.NUM_COLS(NC), .RST_HOLD(HOLD)) u_dut (
    .clk(clk), .por_i(por_i), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pll_lock_i(pll_lock_i), .pll_en_o(pll_en_o), .col_clk_en_o(col_clk_en_o),
    .col_rst_o(col_rst_o), .edge_iso_o(edge_iso_o)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } exp_t;

  localparam int S_PLL = 0, S_CLK = 1, S_RST = 2, S_ISO = 3,
                 S_RCTRL = 4, S_RPART = 5, S_RSTAT = 6, S_R3 = 7;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic push(string r, int s, logic [31:0] e);
    exp_t it;
    it.req = r; it.sel = s; it.exp = e;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [RW-1:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
  endtask

  // monitor: compare queued expectations just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t        it;
        logic [31:0] act;
        it  = q.pop_front();
        act = '0;
        case (it.sel)
          S_PLL: act = 32'(pll_en_o);
          S_CLK: act = 32'(col_clk_en_o);
          S_RST: act = 32'(col_rst_o);
          S_ISO: act = 32'(edge_iso_o);
          default: begin
            reg_raddr = (it.sel == S_RCTRL) ? 2'd0 :
                        (it.sel == S_RPART) ? 2'd1 :
                        (it.sel == S_RSTAT) ? 2'd2 : 2'd3;
            #0.1;
            act = 32'(reg_rdata);
          end
        endcase
        check(it.req, act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NC-2:0] map;
    logic [NC:0]   iso_exp;
    por_i = 1'b1; reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0;
    reg_raddr = '0; pll_lock_i = 1'b0;
    tick(); tick();
    // R1, R2: state under reset, writes ignored
    wr_reg(2'd0, 7'h7);
    push("R2", S_PLL, 0); push("R1", S_CLK, 0); push("R1", S_RST, 0);
    push("R1", S_ISO, 32'h1FF); push("R1", S_RSTAT, 0); push("R2", S_RCTRL, 0);
    tick();
    por_i = 1'b0;
    push("R1", S_PLL, 0); push("R1", S_RSTAT, 0);
    tick();
    // R4: clock request with PLL off
    wr_reg(2'd0, 7'h2); push("R4", S_CLK, 0); push("R4", S_RSTAT, 0); tick();
    // R3: PLL start, clock request before lock ignored (R4)
    wr_reg(2'd0, 7'h3); push("R3", S_PLL, 1); push("R3", S_RSTAT, 1);
    push("R4", S_CLK, 0); tick();
    push("R4", S_RCTRL, 1); tick();
    pll_lock_i = 1'b1; push("R3", S_RSTAT, 2); tick();
    // R6: reset request without clocks ignored
    wr_reg(2'd0, 7'h5); push("R6", S_RST, 0); push("R6", S_RSTAT, 2); tick();
    // R5: clocks on
    wr_reg(2'd0, 7'h3); push("R5", S_CLK, 32'hFF); push("R5", S_RSTAT, 3); tick();
    // R9: map write before running ignored
    wr_reg(2'd1, 7'h7F); push("R9", S_ISO, 32'h1FF); push("R9", S_RPART, 0); tick();
    // R6: reset pulse, R7: early release deferred
    wr_reg(2'd0, 7'h7); push("R6", S_RST, 32'hFF); push("R6", S_RSTAT, 4); tick();
    wr_reg(2'd0, 7'h3); push("R7", S_RST, 32'hFF); tick();
    for (int j = 2; j < HOLD; j++) begin
      push("R7", S_RST, 32'hFF); tick();
    end
    push("R7", S_RST, 0); push("R7", S_RSTAT, 5); tick();
    // R9, R11: partition map
    map = 7'b0110011;
    iso_exp = {1'b1, ~map, 1'b1};
    wr_reg(2'd1, map); push("R9", S_ISO, 32'(iso_exp));
    push("R11", S_RPART, 32'(map)); tick();
    // R6 in running stage, R7 late release
    wr_reg(2'd0, 7'h7); push("R6", S_RSTAT, 4); tick();
    for (int j = 1; j <= HOLD + 2; j++) begin
      push("R7", S_RST, 32'hFF); tick();
    end
    wr_reg(2'd0, 7'h3); push("R7", S_RST, 0); push("R7", S_RSTAT, 5);
    push("R9", S_ISO, 32'(iso_exp)); tick();
    // R5: clocks off and on again
    wr_reg(2'd0, 7'h1); push("R5", S_CLK, 0); push("R5", S_RSTAT, 2); tick();
    wr_reg(2'd0, 7'h3); push("R5", S_CLK, 32'hFF); push("R5", S_RSTAT, 3); tick();
    // R8: lock loss
    pll_lock_i = 1'b0;
    #0.5;
    check("R8", 32'(col_clk_en_o), 0);
    push("R8", S_RSTAT, 9); push("R8", S_ISO, 32'h1FF); push("R8", S_RST, 0);
    tick();
    pll_lock_i = 1'b1; push("R8", S_RSTAT, 32'hA); push("R8", S_CLK, 0); tick();
    // R10: PLL off
    wr_reg(2'd0, 7'h0); push("R10", S_PLL, 0); push("R10", S_RSTAT, 8);
    push("R10", S_CLK, 0); tick();
    push("R11", S_R3, 0); push("R11", S_RCTRL, 0); tick();
    // R1: power-on reset clears sticky flag
    por_i = 1'b1; push("R1", S_RSTAT, 0); tick();
    por_i = 1'b0; tick(); tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule